// File: doc/BRIEF.md
# Latch-Based Binary-Tree 16:1 Serializer

This block turns a 16-bit parallel word into a single serial bit stream running sixteen times faster than the word rate. The words all arrive on the same edge of the slowest clock. The conversion uses a four-level binary tree of 2:1 merge stages: eight stages at the leaves, then four, then two, then one. Every level runs from its own clock, and each clock is twice the frequency of the clock one level closer to the leaves.

Each 2:1 stage is made of level-sensitive latches and one output select, and it needs only one clock phase. The even-input path holds two latches in series. The odd-input path holds three. Because of this, the even path changes only on rising clock edges and the odd path only on falling edges, so the two inputs of the select never change together.

The select passes the even path while its clock is low and the odd path while its clock is high. The caller supplies four ideal clocks, each half the frequency of the one before it, with all rising edges aligned. The word width is set by the tree depth parameter.

Top module: `bintree_serializer`

## Requirements
- R1: Each word leaves on `sout` with bit 0 first and bit 15 last. Each bit occupies exactly one half period of `ck_lvl[0]`, and consecutive words follow back to back with no gap or repeat.
- R2: Bit 0 of a word appears on `sout` 29 half periods of `ck_lvl[0]` (14.5 fast cycles) after the rising edge of `ck_lvl[3]` that captured the word. Bit s starts 29+s half periods after that edge.
- R3: Only the value of `din` present at a rising edge of `ck_lvl[3]` is used. Values held earlier in that slow period, in either clock phase, have no effect on `sout`.
- R4: In each 2:1 stage, the even-input path equals the even input as it was at the previous rising edge of the stage clock. The select passes the even path while the stage clock is low, so even word bits appear on `sout` during the low halves of `ck_lvl[0]`.
- R5: In each 2:1 stage, the odd-input path equals the odd input as it was at the previous rising edge of the stage clock, delayed by one more latch. The select passes the odd path while the stage clock is high, so odd word bits appear during the high halves of `ck_lvl[0]`.
- R6: The even path never changes at a falling edge and the odd path never changes at a rising edge of the stage clock. As a result, `sout` is steady within each half period of `ck_lvl[0]`.
- R7: While `rst_n` is low, every latch is cleared and `sout` is 0, whatever `din` and the clocks do. After release, `sout` stays 0 until a captured word reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ck_lvl | input | 4 (LEVELS) | Tree clocks. Bit 0 is the fastest and drives the final stage; each higher bit is half the frequency of the bit below it; all rising edges are aligned. |
| rst_n | input | 1 | Asynchronous active-low clear of all latches. |
| din | input | 16 (2**LEVELS) | Parallel word, sampled at rising edges of the slowest clock. |
| sout | output | 1 | Serial output, one bit per half period of `ck_lvl[0]`. |

## Verification
Two conditions are hard to reach from the ports. The first is the rule that a word is taken only at the slow rising edge. The second is that the stage paths change on opposite edges. The bench reaches the first by writing decoy words into `din` during both phases of the slow period and leaving the real word in place only shortly before the capturing edge. It reaches the second with alternating-bit words, which put all ones on one path of the final stage and all zeros on the other. It then samples `sout` twice inside every half period, so that a path moving on the wrong edge shows up as a mid-phase change or as the wrong parity of bit.

// File: rtl/bts_pkg.sv
package bts_pkg;

   typedef enum logic {
      OPEN_LOW  = 1'b0,
      OPEN_HIGH = 1'b1
   } lat_phase_e;

   // latch count on the even and odd input paths of one 2:1 stage
   localparam int EVEN_PATH_DEPTH = 2;
   localparam int ODD_PATH_DEPTH  = 3;

   // chain position k: the first latch opens on a low clock, then phases alternate
   function automatic lat_phase_e phase_of(input int k);
      if ((k % 2) == 0) return OPEN_LOW;
      else              return OPEN_HIGH;
   endfunction

endpackage

// File: rtl/bts_latch.sv
module bts_latch #(
   parameter bts_pkg::lat_phase_e PHASE = bts_pkg::OPEN_LOW
) (
   input  logic ck,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (PHASE == bts_pkg::OPEN_HIGH) begin : g_open_high
         always_latch begin
            if (!rst_n)  q <= 1'b0;
            else if (ck) q <= d;
         end
      end else begin : g_open_low
         always_latch begin
            if (!rst_n)   q <= 1'b0;
            else if (!ck) q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/bts_latch_chain.sv
module bts_latch_chain #(
   parameter int DEPTH = 2
) (
   input  logic ck,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [DEPTH:0] tap;

   assign tap[0] = d;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_lat
         bts_latch #(
            .PHASE (bts_pkg::phase_of(k))
         ) u_lat (
            .ck    (ck),
            .rst_n (rst_n),
            .d     (tap[k]),
            .q     (tap[k+1])
         );
      end
   endgenerate

   assign q = tap[DEPTH];

endmodule

// File: rtl/bts_mux_stage.sv
module bts_mux_stage (
   input  logic ck,
   input  logic rst_n,
   input  logic d0,
   input  logic d1,
   output logic q
);

   logic m0;
   logic m1;

   bts_latch_chain #(
      .DEPTH (bts_pkg::EVEN_PATH_DEPTH)
   ) u_even (
      .ck    (ck),
      .rst_n (rst_n),
      .d     (d0),
      .q     (m0)
   );

   bts_latch_chain #(
      .DEPTH (bts_pkg::ODD_PATH_DEPTH)
   ) u_odd (
      .ck    (ck),
      .rst_n (rst_n),
      .d     (d1),
      .q     (m1)
   );

   always_comb q = ck ? m1 : m0;

   // ---------------- checks ----------------
   logic m0_at_fall;
   logic m1_at_rise;

   always_ff @(negedge ck or negedge rst_n) begin
      if (!rst_n) m0_at_fall <= 1'b0;
      else        m0_at_fall <= m0;
   end

   always_ff @(posedge ck or negedge rst_n) begin
      if (!rst_n) m1_at_rise <= 1'b0;
      else        m1_at_rise <= m1;
   end

   AST_EVEN_PATH_DELAY: assert property (@(posedge ck) disable iff (!rst_n)
      $past(rst_n) |-> (m0 == $past(d0)))
      else $error("even path lost the value taken at the last rising edge"); // R4

   AST_ODD_PATH_DELAY: assert property (@(posedge ck) disable iff (!rst_n)
      $past(rst_n) |-> (m1 == $past(d1)))
      else $error("odd path lost the value taken at the last rising edge"); // R5

   AST_EVEN_QUIET_AT_FALL: assert property (@(posedge ck) disable iff (!rst_n)
      m0 == m0_at_fall)
      else $error("even path moved at a falling edge"); // R6

   AST_ODD_QUIET_AT_RISE: assert property (@(negedge ck) disable iff (!rst_n)
      m1 == m1_at_rise)
      else $error("odd path moved at a rising edge"); // R6

endmodule

// File: rtl/bintree_serializer.sv
module bintree_serializer #(
   parameter int LEVELS = 4
) (
   input  logic [LEVELS-1:0]        ck_lvl,
   input  logic                     rst_n,
   input  logic [(1 << LEVELS)-1:0] din,
   output logic                     sout
);

   localparam int WORD_W  = 1 << LEVELS;
   localparam int NODE_W  = 2 * WORD_W - 1;

   // node (level L, index j) sits at (2**L - 1) + j; level LEVELS holds the word bits
   logic [NODE_W-1:0] nd;

   assign nd[WORD_W-1 +: WORD_W] = din;

   generate
      for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
         localparam int BASE  = (1 << lv) - 1;
         localparam int CHILD = (1 << (lv + 1)) - 1;
         localparam int SPAN  = 1 << lv;
         for (genvar ix = 0; ix < SPAN; ix++) begin : g_st
            bts_mux_stage u_stage (
               .ck    (ck_lvl[lv]),
               .rst_n (rst_n),
               .d0    (nd[CHILD + ix]),
               .d1    (nd[CHILD + ix + SPAN]),
               .q     (nd[BASE + ix])
            );
         end
      end
   endgenerate

   assign sout = nd[0];

endmodule

// File: tb/bintree_serializer_tb.sv
module bintree_serializer_tb;

   logic [3:0]  tk = 4'd0;
   logic [3:0]  ck;
   logic        rst_n = 1'b0;
   logic [15:0] din   = 16'hFFFF;
   logic        sout;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] wq [0:63];
   logic [31:0] rs = 32'h1d2c_3b4a;

   // fastest clock: 8 ns period; every clock rises when its counter bit falls
   always #4 tk = tk + 4'd1;
   assign ck = ~tk;

   bintree_serializer #(.LEVELS(4)) u_dut (
      .ck_lvl (ck),
      .rst_n  (rst_n),
      .din    (din),
      .sout   (sout)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] next_word();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs[23:8];
   endfunction

   // Drives wq[0..n-1] on successive slow periods and checks the stream.
   // Bit s of a word starts 29+s fast half periods (116+4s ns) after its capture edge.
   task automatic run_burst(input int n, input bit decoys, input bit by_phase, input string req);
      @(posedge ck[3]);
      fork
         begin
            for (int k = 0; k < n; k++) begin
               if (decoys) begin
                  #4  din = ~wq[k];              // slow clock high
                  #32 din = wq[k] ^ 16'h5A3C;    // slow clock low
                  #16 din = wq[k];
                  #12;
               end else begin
                  #16 din = wq[k];
                  #48;
               end
            end
         end
         begin
            #181;
            for (int k = 0; k < n; k++) begin
               for (int s = 0; s < 16; s++) begin
                  logic v1;
                  string tag;
                  v1 = sout;
                  #2;
                  if (by_phase) tag = (s % 2 == 0) ? "R4" : "R5";
                  else          tag = req;
                  check(tag, $sformatf("word %0d bit %0d", k, s), sout, wq[k][s]);
                  check("R6", $sformatf("steady in half period, word %0d bit %0d", k, s), sout, v1);
                  #2;
               end
            end
         end
      join
   endtask

   task automatic t_reset();
      for (int i = 0; i < 4; i++) begin
         #30;
         check("R7", "output cleared while reset held", sout, 1'b0);
      end
      #40 din = 16'h0000;
      #43 rst_n = 1'b1;          // released at 203 ns, away from clock edges
      #27 check("R7", "output low after release", sout, 1'b0);
      #64 check("R7", "output low before first word", sout, 1'b0);
   endtask

   task automatic t_walk();
      for (int p = 0; p < 16; p++) wq[p] = 16'h0001 << p;
      wq[16] = 16'h8001;
      run_burst(17, 1'b0, 1'b0, "R1");
   endtask

   task automatic t_phase();
      wq[0] = 16'h5555;
      wq[1] = 16'hAAAA;
      wq[2] = 16'h5555;
      wq[3] = 16'hFFFF;
      wq[4] = 16'h0000;
      wq[5] = 16'hAAAA;
      run_burst(6, 1'b0, 1'b1, "R4");
   endtask

   task automatic t_random();
      for (int k = 0; k < 40; k++) wq[k] = next_word();
      run_burst(40, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_decoy();
      for (int k = 0; k < 8; k++) wq[k] = next_word();
      run_burst(8, 1'b1, 1'b0, "R3");
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_walk();
      t_phase();
      t_random();
      t_decoy();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule